// File: doc/BRIEF.md
# Grouped Event Counter Monitor

This block counts hardware events for performance analysis. Every cycle, surrounding logic presents a vector of event strobes, one bit per event class. A set of 32-bit counters, arranged into equal-sized groups, each pick one event class and count the cycles in which that strobe is high. Counting passes through three gates: a global run bit, a per-group run bit and a per-counter enable. When a counter wraps from its maximum value to zero, it raises a sticky overflow flag. A single level interrupt reports any overflow flag whose interrupt enable is set.

Software controls the block through a simple register bus. Each counter has a 1-bit slot in three bitmaps: counter enable, interrupt enable and overflow status. The bitmaps are packed 32 counters per 32-bit word. Enable and interrupt enable are changed through separate set and clear addresses, so no read-modify-write is needed. Overflow status is cleared by writing 1s. The bus takes one request per cycle and always accepts it, so it applies no back-pressure. A read returns its data on the cycle after the request, with a one-cycle valid pulse.

Address map, as byte addresses, where n is the counter number, g is the group number and w is the bitmap word:

- 0x000: global control
- 0x004: configuration (read only)
- 0x100+4g: group control
- 0x200+4w: enable set
- 0x240+4w: enable clear
- 0x280+4w: interrupt-enable set
- 0x2C0+4w: interrupt-enable clear
- 0x300+4w: overflow status
- 0x400+4n: count
- 0x800+4n: event type

Any other address reads as 0, and writes to it have no effect. The number of counters per group must not exceed 15, and the number of counters must not exceed 256.

Top module: `pmon_top`

## Requirements
- R1: While bit 0 of global control (0x000) is 0, no counter changes except by a software write or a zeroing command. Bit 0 reads back as written.
- R2: Writing global control with bit 1 set zeroes every counter on that clock edge. Bit 1 always reads back as 0. Zeroing has priority over counting.
- R3: Group control at 0x100+4g has its run bit at bit 11, which reads back. Bits 27:24 read as the number of counters in the group. Clearing bit 11 stops every counter in that group.
- R4: The configuration word at 0x004 reads {number of groups minus 1 in bits 31:24, number of counters minus 1 in bits 7:0}, with every other bit 0.
- R5: Counter n uses bit n%32 of bitmap word n/32. Writing 1s to enable set (0x200+4w) turns those enables on. Writing 1s to enable clear (0x240+4w) turns them off. Zero bits change nothing. Both addresses read back the current enable word.
- R6: The interrupt enable works the same way as R5, with its set register at 0x280+4w and its clear register at 0x2C0+4w.
- R7: Overflow status at 0x300+4w is write-one-to-clear. Writing 0s changes nothing, and writing back a value that was read clears exactly the flags that were set in it.
- R8: The event type register at 0x800+4n selects the strobe index counter n counts. The counter adds 1 on each rising edge where its selected strobe is high and the global, group and counter enables are all 1.
- R9: A counter at 0xFFFFFFFF that counts becomes 0 and sets its overflow flag.
- R10: irq_o is high exactly while some overflow flag and its interrupt-enable bit are both 1. It is combinational from those flops.
- R11: If a counter wraps on the same edge that software clears its overflow flag, the flag ends up set.
- R12: The count register at 0x400+4n can be read at any time and loaded by a write. A load has priority over counting.
- R13: A read request sets bus_rvalid_o for exactly the next cycle. That cycle carries the value the register held at the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Register request present this cycle; always accepted |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata_o | output | 32 | Read data |
| evt_i | input | NUM_EVENTS | Event strobes, indexed by event class |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The bench builds the block with three groups of twelve counters, which gives 36 counters, and four event classes. With 36 counters, the bitmaps span two words, so bit positions in the second word (counter 35) are reached. With three groups, one group can be gated off while counters in the other groups keep counting. A count field of twelve also fits the 4-bit group-size field. Wraps are reached by loading counts near the maximum, and the bench drives a wrap and a clear of the same flag in one cycle.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int BM_BITS = 32;
  localparam int GCTRL_RUN_BIT = 0;
  localparam int GCTRL_ZERO_BIT = 1;
  localparam int GRP_RUN_BIT = 11;

  typedef enum logic [2:0] {
    BM_NOP,
    BM_EN_SET,
    BM_EN_CLR,
    BM_IE_SET,
    BM_IE_CLR,
    BM_OVF_W1C
  } bm_op_e;

  function automatic logic [DATA_W-1:0] cfg_word(input int n_ctr, input int n_grp);
    logic [DATA_W-1:0] w;
    w = '0;
    w[7:0] = 8'(n_ctr - 1);
    w[31:24] = 8'(n_grp - 1);
    return w;
  endfunction
endpackage

// File: rtl/pmon_counter.sv
module pmon_counter #(
  parameter int CNT_W = 32,
  parameter int NUM_EVENTS = 16,
  localparam int EVT_W = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_EVENTS-1:0] evt_i,
  input  logic                  gate_i,
  input  logic                  zero_i,
  input  logic                  cnt_we_i,
  input  logic                  typ_we_i,
  input  logic [31:0]           wdata_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [EVT_W-1:0]      typ_o,
  output logic                  wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [EVT_W-1:0] typ_q;
  logic             hit;
  logic             bump;

  always_comb begin
    hit = 1'b0;
    if (int'(typ_q) < NUM_EVENTS) hit = evt_i[typ_q];
  end

  assign bump   = gate_i & hit;
  assign wrap_o = bump & (&cnt_q) & ~zero_i & ~cnt_we_i;
  assign cnt_o  = cnt_q;
  assign typ_o  = typ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      typ_q <= '0;
    end else begin
      if (typ_we_i) typ_q <= wdata_i[EVT_W-1:0];
      if (zero_i)        cnt_q <= '0;
      else if (cnt_we_i) cnt_q <= wdata_i[CNT_W-1:0];
      else if (bump)     cnt_q <= cnt_q + 1'b1;
    end
  end

  p_hold_when_gated_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_i && !zero_i && !cnt_we_i) |=> $stable(cnt_q));
  p_zero_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |=> (cnt_q == '0));
  p_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bump && !zero_i && !cnt_we_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  p_wrap_to_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  p_load_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_we_i && !zero_i) |=> (cnt_q == CNT_W'($past(wdata_i))));
endmodule

// File: rtl/pmon_bitmap.sv
module pmon_bitmap
  import pmon_pkg::*;
#(
  parameter int N = 16,
  localparam int NW = (N + BM_BITS - 1) / BM_BITS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  bm_op_e                op_i,
  input  logic [3:0]            word_i,
  input  logic [31:0]           wdata_i,
  input  logic [N-1:0]          wrap_i,
  output logic [NW*BM_BITS-1:0] en_o,
  output logic [NW*BM_BITS-1:0] ie_o,
  output logic [NW*BM_BITS-1:0] ovf_o,
  output logic                  irq_o
);
  for (genvar i = 0; i < NW * BM_BITS; i++) begin : g_bit
    if (i < N) begin : g_live
      localparam int WORD = i / BM_BITS;
      localparam int BIT  = i % BM_BITS;
      logic hit;
      logic en_r, ie_r, ovf_r;

      assign hit = (word_i == 4'(WORD)) && wdata_i[BIT];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          en_r  <= 1'b0;
          ie_r  <= 1'b0;
          ovf_r <= 1'b0;
        end else begin
          if (hit && op_i == BM_EN_SET)      en_r <= 1'b1;
          else if (hit && op_i == BM_EN_CLR) en_r <= 1'b0;
          if (hit && op_i == BM_IE_SET)      ie_r <= 1'b1;
          else if (hit && op_i == BM_IE_CLR) ie_r <= 1'b0;
          if (wrap_i[i])                      ovf_r <= 1'b1;
          else if (hit && op_i == BM_OVF_W1C) ovf_r <= 1'b0;
        end
      end

      assign en_o[i]  = en_r;
      assign ie_o[i]  = ie_r;
      assign ovf_o[i] = ovf_r;

      p_en_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit && op_i == BM_EN_CLR) |=> !en_r);
      p_ie_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit && op_i == BM_IE_SET) |=> ie_r);
      p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit && op_i == BM_OVF_W1C && !wrap_i[i]) |=> !ovf_r);
      p_no_overflow_loss_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_i[i] |=> ovf_r);
    end else begin : g_pad
      assign en_o[i]  = 1'b0;
      assign ie_o[i]  = 1'b0;
      assign ovf_o[i] = 1'b0;
    end
  end

  assign irq_o = |(ovf_o & ie_o);
endmodule

// File: rtl/pmon_top.sv
module pmon_top
  import pmon_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int CTRS_PER_GRP = 4,
  parameter int NUM_EVENTS = 16,
  parameter int CNT_W = 32,
  localparam int N = NUM_GROUPS * CTRS_PER_GRP,
  localparam int NW = (N + BM_BITS - 1) / BM_BITS,
  localparam int EVT_W = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_valid_i,
  input  logic                  bus_write_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic                  bus_rvalid_o,
  output logic [DATA_W-1:0]     bus_rdata_o,
  input  logic [NUM_EVENTS-1:0] evt_i,
  output logic                  irq_o
);
  logic wr, rd;
  logic sel_misc, sel_cnt, sel_typ;
  logic [1:0] sub, kind;
  logic [5:0] idx6;
  logic [3:0] widx;
  int cidx;

  assign wr = bus_valid_i & bus_write_i;
  assign rd = bus_valid_i & ~bus_write_i;
  assign sel_misc = bus_addr_i[11:10] == 2'd0;
  assign sel_cnt  = bus_addr_i[11:10] == 2'd1;
  assign sel_typ  = bus_addr_i[11:10] == 2'd2;
  assign sub  = bus_addr_i[9:8];
  assign kind = bus_addr_i[7:6];
  assign idx6 = bus_addr_i[7:2];
  assign widx = bus_addr_i[5:2];
  assign cidx = int'(bus_addr_i[9:2]);

  logic gctrl_wr, zero_pulse, glb_run_q;
  logic [NUM_GROUPS-1:0] grp_run_q;

  assign gctrl_wr   = wr && sel_misc && sub == 2'd0 && idx6 == 6'd0;
  assign zero_pulse = gctrl_wr && bus_wdata_i[GCTRL_ZERO_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_run_q <= 1'b0;
    end else if (gctrl_wr) begin
      glb_run_q <= bus_wdata_i[GCTRL_RUN_BIT];
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic grp_wr;
    assign grp_wr = wr && sel_misc && sub == 2'd1 && kind == 2'd0 && widx == 4'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     grp_run_q[g] <= 1'b0;
      else if (grp_wr) grp_run_q[g] <= bus_wdata_i[GRP_RUN_BIT];
    end
  end

  bm_op_e bm_op;
  always_comb begin
    bm_op = BM_NOP;
    if (wr && sel_misc) begin
      if (sub == 2'd2) begin
        unique case (kind)
          2'd0: bm_op = BM_EN_SET;
          2'd1: bm_op = BM_EN_CLR;
          2'd2: bm_op = BM_IE_SET;
          default: bm_op = BM_IE_CLR;
        endcase
      end else if (sub == 2'd3 && kind == 2'd0) begin
        bm_op = BM_OVF_W1C;
      end
    end
  end

  logic [NW*BM_BITS-1:0] en_v, ie_v, ovf_v;
  logic [N-1:0] wrap_v;
  logic [CNT_W-1:0] cnt_arr [N];
  logic [EVT_W-1:0] typ_arr [N];

  pmon_bitmap #(.N(N)) u_bitmap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (bm_op),
    .word_i  (widx),
    .wdata_i (bus_wdata_i),
    .wrap_i  (wrap_v),
    .en_o    (en_v),
    .ie_o    (ie_v),
    .ovf_o   (ovf_v),
    .irq_o   (irq_o)
  );

  for (genvar n = 0; n < N; n++) begin : g_ctr
    logic gate, cnt_we, typ_we;
    assign gate   = glb_run_q & grp_run_q[n / CTRS_PER_GRP] & en_v[n];
    assign cnt_we = wr && sel_cnt && cidx == n;
    assign typ_we = wr && sel_typ && cidx == n;
    pmon_counter #(.CNT_W(CNT_W), .NUM_EVENTS(NUM_EVENTS)) u_ctr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_i),
      .gate_i   (gate),
      .zero_i   (zero_pulse),
      .cnt_we_i (cnt_we),
      .typ_we_i (typ_we),
      .wdata_i  (bus_wdata_i),
      .cnt_o    (cnt_arr[n]),
      .typ_o    (typ_arr[n]),
      .wrap_o   (wrap_v[n])
    );
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (sel_misc) begin
      unique case (sub)
        2'd0: begin
          if (idx6 == 6'd0)      rd_next[GCTRL_RUN_BIT] = glb_run_q;
          else if (idx6 == 6'd1) rd_next = cfg_word(N, NUM_GROUPS);
        end
        2'd1: begin
          if (kind == 2'd0 && int'(widx) < NUM_GROUPS) begin
            rd_next[27:24] = 4'(CTRS_PER_GRP);
            rd_next[GRP_RUN_BIT] = grp_run_q[widx];
          end
        end
        2'd2: begin
          if (int'(widx) < NW) begin
            if (kind[1]) rd_next = ie_v[widx*BM_BITS +: BM_BITS];
            else         rd_next = en_v[widx*BM_BITS +: BM_BITS];
          end
        end
        default: begin
          if (kind == 2'd0 && int'(widx) < NW) rd_next = ovf_v[widx*BM_BITS +: BM_BITS];
        end
      endcase
    end else if (sel_cnt) begin
      if (cidx < N) rd_next = DATA_W'(cnt_arr[cidx]);
    end else if (sel_typ) begin
      if (cidx < N) rd_next = DATA_W'(typ_arr[cidx]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rvalid_o <= 1'b0;
      bus_rdata_o  <= '0;
    end else begin
      bus_rvalid_o <= rd;
      bus_rdata_o  <= rd ? rd_next : '0;
    end
  end

  p_zero_bit_reads_0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel_misc && sub == 2'd0 && idx6 == 6'd0) |=> !bus_rdata_o[GCTRL_ZERO_BIT]);
  p_run_bit_rb_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gctrl_wr |=> (glb_run_q == $past(bus_wdata_i[GCTRL_RUN_BIT])));
  p_rvalid_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> bus_rvalid_o);
  p_rvalid_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !bus_rvalid_o);
  p_irq_needs_enable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_v == '0) |-> !irq_o);
endmodule

// File: tb/tb_pmon_top.sv
`timescale 1ns/1ps
module tb_pmon_top;
  localparam int NG = 3;
  localparam int CPG = 12;
  localparam int NE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0;
  logic bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_rvalid;
  logic [31:0] bus_rdata;
  logic [NE-1:0] evt = '0;
  logic irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  pmon_top #(.NUM_GROUPS(NG), .CTRS_PER_GRP(CPG), .NUM_EVENTS(NE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rvalid_o(bus_rvalid),
    .bus_rdata_o(bus_rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic pulse(input logic [NE-1:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); evt = m;
      @(negedge clk); evt = '0;
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq actual %0b expected %0b", t, irq, e);
    end
  endtask

  // monitor: pops scoreboard entries as read data appears
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      logic [31:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R13: unexpected read data actual %08h expected none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %08h expected %08h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    chk_irq(1'b0, "R10 reset irq");
    rd(12'h004, 32'h0200_0023, "R4 config");
    rd(12'h000, 32'h0, "R1 reset gctrl");
    rd(12'h100, 32'h0C00_0000, "R3 group size field");
    rd(12'h200, 32'h0, "R5 reset enables");
    rd(12'h300, 32'h0, "R7 reset overflow");
    rd(12'h400, 32'h0, "R12 reset count");
    // event types and enables
    wr(12'h804, 32'd1);
    wr(12'h834, 32'd2);
    wr(12'h88C, 32'd3);
    rd(12'h88C, 32'd3, "R8 type readback");
    wr(12'h200, 32'h0000_2003);
    wr(12'h204, 32'h0000_0008);
    rd(12'h204, 32'h8, "R5 second word bit 3");
    wr(12'h100, 32'h800);
    wr(12'h104, 32'h800);
    wr(12'h108, 32'h800);
    rd(12'h100, 32'h0C00_0800, "R3 run bit readback");
    // global off: nothing counts
    pulse(4'hF, 3);
    rd(12'h400, 32'd0, "R1 gated c0");
    rd(12'h48C, 32'd0, "R1 gated c35");
    // global on
    wr(12'h000, 32'h1);
    rd(12'h000, 32'h1, "R1 run bit readback");
    pulse(4'h1, 2);
    pulse(4'h2, 1);
    pulse(4'hF, 1);
    rd(12'h400, 32'd3, "R8 c0 class 0");
    rd(12'h404, 32'd2, "R8 c1 class 1");
    rd(12'h434, 32'd1, "R8 c13 class 2");
    rd(12'h48C, 32'd1, "R8 c35 class 3");
    // group 1 off
    wr(12'h104, 32'h0);
    pulse(4'hF, 1);
    rd(12'h434, 32'd1, "R3 group gated c13");
    rd(12'h400, 32'd4, "R3 other group c0");
    rd(12'h48C, 32'd2, "R3 other group c35");
    // counter 1 disabled via clear register
    wr(12'h240, 32'h2);
    rd(12'h200, 32'h2001, "R5 set reg after clear");
    rd(12'h240, 32'h2001, "R5 clear reg readback");
    pulse(4'hF, 1);
    rd(12'h404, 32'd3, "R5 disabled c1 holds");
    rd(12'h400, 32'd5, "R5 enabled c0 counts");
    // zero command
    wr(12'h000, 32'h3);
    rd(12'h000, 32'h1, "R2 zero bit reads 0");
    rd(12'h400, 32'd0, "R2 c0 zeroed");
    rd(12'h48C, 32'd0, "R2 c35 zeroed");
    // wrap
    wr(12'h48C, 32'hFFFF_FFFE);
    rd(12'h48C, 32'hFFFF_FFFE, "R12 load");
    pulse(4'h8, 2);
    rd(12'h48C, 32'd0, "R9 wrap to zero");
    rd(12'h304, 32'h8, "R9 overflow flag");
    chk_irq(1'b0, "R10 no irq without enable");
    wr(12'h284, 32'h8);
    rd(12'h2C4, 32'h8, "R6 ie readback");
    chk_irq(1'b1, "R10 irq raised");
    wr(12'h304, 32'h0);
    rd(12'h304, 32'h8, "R7 zero write no effect");
    wr(12'h304, 32'h8);
    rd(12'h304, 32'h0, "R7 w1c clears");
    chk_irq(1'b0, "R10 irq dropped");
    wr(12'h2C4, 32'h8);
    rd(12'h284, 32'h0, "R6 ie clear");
    // same-cycle wrap and clear on counter 0
    wr(12'h400, 32'hFFFF_FFFF);
    @(negedge clk);
    evt = 4'h1; bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h300; bus_wdata = 32'h1;
    @(negedge clk);
    evt = '0; bus_valid = 1'b0; bus_write = 1'b0;
    rd(12'h300, 32'h1, "R11 overflow wins");
    rd(12'h400, 32'h0, "R11 c0 wrapped");
    wr(12'h300, 32'h1);
    rd(12'h300, 32'h0, "R7 clear after collision");
    rd(12'h9FC, 32'h0, "R13 unmapped reads 0");
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R13: missing reads actual %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule